// File: doc/BRIEF.md
# Multicycle Subset Processor Core

This block is a 32-bit processor core that runs a small integer instruction subset: word load and store, register add, subtract, and, or, signed set-less-than, branch-on-equal and jump. Each instruction takes a sequence of three to five clock steps. A single ALU and a single memory port are shared across those steps. Holding registers carry values from one step to the next: the instruction word, the memory data, the two register operands and the ALU result.

Instructions and data come from the same memory. Read data must be valid in the same cycle as the address, so the read is combinational. A write takes effect on the rising clock edge while the write strobe is high. The `ifetch` output is high during the step that reads an instruction, so the surrounding logic can tell instruction reads from data reads.

Top module: `mc_core`

## Requirements
- R1: While reset is low the core sits in its fetch step with PC = 0. In the first cycle after reset goes high, `ifetch` is 1 and `mem_addr` is 0.
- R2: Every instruction starts with a fetch step that lasts one cycle. In that step `ifetch` is 1, `mem_addr` equals PC and the word read becomes the instruction. PC then advances by 4.
- R3: Opcode 000000 is a register operation. It writes rs op rt into register rd (bits 15:11). Funct 100000 selects add, 100010 sub, 100100 and, and 100101 or. Funct 101010 selects slt.
- R4: Opcode 100011 (load) reads the word at rs + sign-extended imm16 into register rt (bits 20:16). Opcode 101011 (store) writes rt to that address. A negative offset subtracts from the base.
- R5: Opcode 000100 (branch) sets PC to PC+4 + (sign-extended imm16 << 2) only when rs equals rt. Otherwise execution continues at PC+4.
- R6: Opcode 000010 (jump) sets PC to {upper 4 bits of PC+4, bits 25:0 of the instruction, 00}.
- R7: From one fetch to the next takes 3 cycles for branch and jump, 4 for register operations and stores, and 5 for loads.
- R8: Register 0 always reads as zero. A write to register 0 has no effect.
- R9: slt gives 1 when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R10: `mem_we` is high only in the final step of a store. In that step `mem_wdata` is the rt value, and no stray memory write occurs on any other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for instruction or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| ifetch | output | 1 | High during the instruction fetch step |

## Verification
The register operations are driven with random operand pairs, with random pairs that are equal, with negative values against small positive ones, and with the pair 0x80000000 and 0x7FFFFFFF. The equal pairs expose a sub or slt that gets zero wrong, and the sign-boundary pair tells a signed comparison from an unsigned one. Each result is stored through a base register with a negative offset, loaded back and stored again, which tests the offset sign extension on both the load and store paths. A directed program contains a taken branch, a branch that is not taken, a jump over an instruction, and an add whose destination is register 0. In that program the bench times the gap between fetches and records which addresses were fetched, so skipped instructions, step counts and the zero register are all checked at the memory port.

// File: rtl/mc_core.sv
module mc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  output logic        ifetch
);
  localparam logic [5:0] OP_R   = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_J   = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_RUN, S_BEQ, S_JMP, S_LOAD, S_STORE, S_RWB, S_LWB
  } step_t;

  step_t       st_q, st_d;
  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [31:0] rf [32];

  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [31:0] imm_x, rs_val, rt_val;
  logic [31:0] src_a, src_b, alu_y;
  logic [1:0]  alu_sel;
  logic [3:0]  alu_ctl;
  logic        alu_zero;
  logic        rf_we;
  logic [4:0]  rf_wa;
  logic [31:0] rf_wd;

  assign opcode = ir_q[31:26];
  assign rs     = ir_q[25:21];
  assign rt     = ir_q[20:16];
  assign rd     = ir_q[15:11];
  assign funct  = ir_q[5:0];
  assign imm_x  = {{16{ir_q[15]}}, ir_q[15:0]};
  assign rs_val = (rs == 5'd0) ? 32'h0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'h0 : rf[rt];

  always_comb begin
    src_a   = a_q;
    src_b   = b_q;
    alu_sel = 2'b00;
    case (st_q)
      S_FETCH:  begin src_a = pc_q; src_b = 32'd4; end
      S_DECODE: begin src_a = pc_q; src_b = {imm_x[29:0], 2'b00}; end
      S_ADDR:   src_b = imm_x;
      S_BEQ:    alu_sel = 2'b01;
      S_RUN:    alu_sel = 2'b10;
      default:  ;
    endcase
  end

  always_comb begin
    alu_ctl = 4'b0010;
    if (alu_sel == 2'b01) alu_ctl = 4'b0110;
    else if (alu_sel == 2'b10) begin
      case (funct)
        6'b100010: alu_ctl = 4'b0110;
        6'b100100: alu_ctl = 4'b0000;
        6'b100101: alu_ctl = 4'b0001;
        6'b101010: alu_ctl = 4'b0111;
        default:   alu_ctl = 4'b0010;
      endcase
    end
  end

  always_comb begin
    case (alu_ctl)
      4'b0000: alu_y = src_a & src_b;
      4'b0001: alu_y = src_a | src_b;
      4'b0110: alu_y = src_a - src_b;
      4'b0111: alu_y = {31'h0, $signed(src_a) < $signed(src_b)};
      default: alu_y = src_a + src_b;
    endcase
  end
  assign alu_zero = (alu_y == 32'h0);

  always_comb begin
    st_d = S_FETCH;
    case (st_q)
      S_FETCH: st_d = S_DECODE;
      S_DECODE:
        case (opcode)
          OP_LW, OP_SW: st_d = S_ADDR;
          OP_R:         st_d = (ir_q[10:6] == 5'd0) ? S_RUN : S_FETCH;
          OP_BEQ:       st_d = S_BEQ;
          OP_J:         st_d = S_JMP;
          default:      st_d = S_FETCH;
        endcase
      S_ADDR:  st_d = (opcode == OP_LW) ? S_LOAD : S_STORE;
      S_LOAD:  st_d = S_LWB;
      S_RUN:   st_d = S_RWB;
      default: st_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_FETCH;
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      case (st_q)
        S_FETCH: begin
          ir_q <= mem_rdata;
          pc_q <= alu_y;
        end
        S_DECODE: begin
          a_q   <= rs_val;
          b_q   <= rt_val;
          res_q <= alu_y;
        end
        S_ADDR, S_RUN: res_q <= alu_y;
        S_BEQ:  if (alu_zero) pc_q <= res_q;
        S_JMP:  pc_q <= {pc_q[31:28], ir_q[25:0], 2'b00};
        S_LOAD: mdr_q <= mem_rdata;
        default: ;
      endcase
    end
  end

  assign rf_we = (st_q == S_RWB) || (st_q == S_LWB);
  assign rf_wa = (st_q == S_LWB) ? rt : rd;
  assign rf_wd = (st_q == S_LWB) ? mdr_q : res_q;

  always_ff @(posedge clk) begin
    if (rf_we && rf_wa != 5'd0) rf[rf_wa] <= rf_wd;
  end

  assign ifetch    = (st_q == S_FETCH);
  assign mem_addr  = ifetch ? pc_q : res_q;
  assign mem_we    = (st_q == S_STORE);
  assign mem_wdata = b_q;
endmodule

module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ifetch,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] pc_q
);
  logic [2:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 3'd0;
    else if (ifetch) gap <= 3'd1;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  // R2
  fetch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch |=> !ifetch);
  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch |-> mem_addr == pc_q);
  // R2
  fetch_step_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch |=> pc_q == $past(pc_q) + 32'd4);
  // R7
  max_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap >= 3'd5) |-> ifetch);
  // R7
  min_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch && gap != 3'd0) |-> gap >= 3'd3);
  // R10
  store_not_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !ifetch);
  // R10
  store_last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ifetch);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ifetch(ifetch), .mem_we(mem_we),
  .mem_addr(mem_addr), .pc_q(pc_q)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, ifetch;
  logic [31:0] mem [256];
  int total = 0, bad = 0;
  int dur [64];
  bit seen [64];

  always #4 clk = ~clk;

  mc_core u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
              .mem_we(mem_we), .mem_rdata(mem_rdata), .ifetch(ifetch));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] rop(input logic [4:0] s, t, d, input logic [5:0] f);
    return {6'd0, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input logic [4:0] s, t,
                                      input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction
  function automatic logic [31:0] jop(input logic [31:0] target);
    return {6'b000010, target[27:2]};
  endfunction
  function automatic logic [31:0] ref_op(input logic [5:0] f, input logic [31:0] a, b);
    case (f)
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) begin dur[i] = 0; seen[i] = 1'b0; end
  endtask

  task automatic run_prog(input logic [31:0] halt);
    int cyc, prev;
    bit done;
    #1;
    chk("R1 ifetch after reset", {31'h0, ifetch}, 32'd1);
    chk("R1 first address", mem_addr, 32'h0);
    prev = 0; seen[0] = 1'b1; cyc = 1; done = 1'b0;
    for (int n = 0; n < 4000 && !done; n++) begin
      @(negedge clk);
      if (ifetch) begin
        dur[prev] = cyc;
        cyc = 1;
        prev = int'(mem_addr[7:2]);
        seen[prev] = 1'b1;
        if (mem_addr == halt) done = 1'b1;
      end else cyc++;
    end
    if (!done) chk("R2 reached halt", 32'd0, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;
  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100,
                         F_OR = 6'b100101, F_SLT = 6'b101010;

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b, r;
    logic [5:0] fsel [5];
    fsel[0] = F_ADD; fsel[1] = F_SUB; fsel[2] = F_AND; fsel[3] = F_OR; fsel[4] = F_SLT;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);

    // Directed program: branches, jump, r0, step counts
    a = 32'h1234_5678; b = 32'h0F0F_0F0F;
    clear_mem();
    mem[0]  = iop(LW, 5'd0, 5'd1, 16'h0200);
    mem[1]  = iop(LW, 5'd0, 5'd2, 16'h0204);
    mem[2]  = rop(5'd1, 5'd2, 5'd3, F_ADD);
    mem[3]  = iop(SW, 5'd0, 5'd3, 16'h0208);
    mem[4]  = iop(BEQ, 5'd1, 5'd1, 16'h0001);
    mem[5]  = iop(SW, 5'd0, 5'd1, 16'h020C);
    mem[6]  = iop(BEQ, 5'd1, 5'd2, 16'h0001);
    mem[7]  = rop(5'd1, 5'd2, 5'd0, F_ADD);
    mem[8]  = iop(SW, 5'd0, 5'd0, 16'h0210);
    mem[9]  = jop(32'h2C);
    mem[10] = iop(SW, 5'd0, 5'd1, 16'h020C);
    mem[11] = jop(32'h2C);
    mem[128] = a; mem[129] = b; mem[131] = 32'hDEAD_BEEF; mem[132] = 32'h5555_AAAA;
    @(negedge clk); rst_n = 1'b1;
    run_prog(32'h2C);
    chk("R3 add result", mem[130], a + b);
    chk("R5 taken branch skips store", mem[131], 32'hDEAD_BEEF);
    chk("R5 skipped address never fetched", {31'h0, seen[5]}, 32'd0);
    chk("R5 not-taken branch falls through", {31'h0, seen[7]}, 32'd1);
    chk("R6 jump skips address", {31'h0, seen[10]}, 32'd0);
    chk("R8 r0 stays zero", mem[132], 32'h0);
    chk("R7 load steps", dur[0], 32'd5);
    chk("R7 R-type steps", dur[2], 32'd4);
    chk("R7 store steps", dur[3], 32'd4);
    chk("R7 taken branch steps", dur[4], 32'd3);
    chk("R7 untaken branch steps", dur[6], 32'd3);
    chk("R7 jump steps", dur[9], 32'd3);
    chk("R10 sentinel untouched", mem[131], 32'hDEAD_BEEF);

    // Random register operations with load/store through negative offset
    for (int it = 0; it < 40; it++) begin
      logic [5:0] f;
      int mode;
      mode = int'($urandom % 4);
      a = $urandom; b = $urandom;
      if (mode == 1) b = a;
      if (mode == 2) begin a = -($urandom % 1000) - 1; b = $urandom % 1000; end
      if (mode == 3) begin a = 32'h8000_0000; b = 32'h7FFF_FFFF; end
      if (it < 5) f = fsel[it]; else f = fsel[$urandom % 5];
      if (it == 4) begin a = 32'h8000_0000; b = 32'h7FFF_FFFF; end
      if (it == 5) begin f = F_SLT; a = 32'h7FFF_FFFF; b = 32'h8000_0000; end
      r = ref_op(f, a, b);
      clear_mem();
      mem[0] = iop(LW, 5'd0, 5'd1, 16'h0200);
      mem[1] = iop(LW, 5'd0, 5'd2, 16'h0204);
      mem[2] = iop(LW, 5'd0, 5'd4, 16'h020C);
      mem[3] = rop(5'd1, 5'd2, 5'd3, f);
      mem[4] = iop(SW, 5'd4, 5'd3, 16'hFFFC);
      mem[5] = iop(LW, 5'd4, 5'd5, 16'hFFFC);
      mem[6] = iop(SW, 5'd0, 5'd5, 16'h0208);
      mem[7] = jop(32'h1C);
      mem[128] = a; mem[129] = b; mem[131] = 32'h0000_0300;
      @(negedge clk); rst_n = 1'b1;
      run_prog(32'h1C);
      if (f == F_SLT) chk("R9 slt signed", mem[191], r);
      else chk("R3 register op", mem[191], r);
      chk("R4 load/store negative offset", mem[130], r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule